// File: doc/BRIEF.md
# PCI DMA Window Translator

This block sits on the inbound path of a PCI host bridge. Every memory address that a PCI master presents for DMA is compared against five programmable windows in PCI memory space. Only an address that falls in a window may reach system memory. Each window is either direct-mapped or scatter/gather-mapped. A direct-mapped window adds the offset inside the window to a translated base. A scatter/gather window sends each 8 KB PCI page to any 8 KB system page through a small internal page-entry array.

Inbound addresses come as a 32-bit single address cycle or a 64-bit dual address cycle. A flag marks accesses to configuration space, and those are never translated. Software programs the windows through a register-write port that selects window and field, and programs the page entries through a separate port. The result appears one cycle after the request: a hit flag, an error flag for a failed page lookup, the index of the deciding window, and the translated system address.

Top module: `dwx_window_xlate`

## Requirements
- R1: After reset, window 0 is scatter/gather, 8 MB (mask 0x007F_FFFF), base 0, and disabled. Window 1 is enabled and direct-mapped, with base 0x4000_0000, mask 0x3FFF_FFFF and translated frame 0, so PCI 0x4000_0000–0x7FFF_FFFF maps onto system 0–1 GB. Windows 2 to 4 are disabled. All page entries are invalid.
- R2: A window matches when its enable bit is set and the low 32 address bits, with the mask bits cleared, equal its base with the mask bits cleared. The mask bits are the offset bits inside the window.
- R3: When several windows match, the lowest index decides, and out_win reports it.
- R4: A direct-mapped window outputs (translated frame × 8192) + (address AND mask).
- R5: In a scatter/gather window, the page index is (address AND mask) >> 13. The entry at that index holds a valid bit in bit FRAME_W and a frame number in the bits below it. A valid entry gives the output {frame, address[12:0]}.
- R6: If the entry is invalid, or the page index is SG_DEPTH or more, the result is out_err=1, out_hit=0 and out_addr=0, with out_win naming that window. No lower-priority window is tried.
- R7: With in_dac=0, address bits 63:32 are ignored.
- R8: With in_dac=1 and any of bits 63:32 set, only windows whose dual-address-accept bit is set can match.
- R9: A request with in_cfg=1 gives out_hit=0 and out_err=0.
- R10: out_valid follows in_valid with one cycle of latency. When out_valid=0, all other outputs are 0. A request that matches no window gives out_hit=0, out_err=0, out_win=0 and out_addr=0.
- R11: The cfg_fld codes are 0 = base, 1 = mask, 2 = control and 3 = translated frame. The frame is system address bits [SYS_AW-1:13], taken from cfg_wdata[FRAME_W-1:0]. The control bits are bit0 enable, bit1 scatter/gather and bit2 dual-address accept. Window and page-entry writes apply to requests issued in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | WIN_IDX_W | Window selected for the write |
| cfg_fld | input | 2 | Field code (R11) |
| cfg_wdata | input | 32 | Write data |
| pte_we | input | 1 | Page-entry write strobe |
| pte_idx | input | PTE_IDX_W | Page-entry index |
| pte_wdata | input | FRAME_W+1 | {valid, frame} |
| in_valid | input | 1 | Request strobe |
| in_dac | input | 1 | Request is a dual address cycle |
| in_cfg | input | 1 | Request targets configuration space |
| in_addr | input | 64 | Inbound PCI address |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_hit | output | 1 | Translation succeeded |
| out_err | output | 1 | Scatter/gather page lookup failed |
| out_win | output | WIN_IDX_W | Deciding window |
| out_addr | output | SYS_AW | Translated system address |

## Verification
The bench enables window 0 so that it overlaps the lower part of window 2, and probes both the overlap and the region just past window 0. A wrong priority order would return window 2's direct address instead. It sends requests to invalid and out-of-range page entries inside window 0. A design that fell through to window 2 would report a hit where an error is due. It also probes the first and last byte of each window and one byte past the end, which catches a mask compare that is off by one. Dual-cycle requests with high bits set are sent both to a window that refuses them and to one that accepts them, and the same high bits are sent on a single-cycle request. A design that ignored the accept bit, or that looked at the high bits on single cycles, would change hit into miss or miss into hit.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
    localparam int PCI_LO_W = 32;
    localparam int PAGE_SH  = 13;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_XLAT = 2'd3
    } cfg_fld_e;

    // packed so that dac_ok is bit 2, sg bit 1, en bit 0
    typedef struct packed {
        logic dac_ok;
        logic sg;
        logic en;
    } win_ctrl_t;

    typedef struct packed {
        win_ctrl_t             ctrl;
        logic [PCI_LO_W-1:0]   base;
        logic [PCI_LO_W-1:0]   mask;
    } win_cfg_t;
endpackage

// File: rtl/dwx_win_regs.sv
module dwx_win_regs
    import dwx_pkg::*;
#(
    parameter int  NUM_WIN   = 5,
    parameter int  FRAME_W   = 21,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [WIN_IDX_W-1:0] cfg_win,
    input  logic [1:0]           cfg_fld,
    input  logic [31:0]          cfg_wdata,
    output win_cfg_t             win_cfg   [NUM_WIN],
    output logic [FRAME_W-1:0]   win_frame [NUM_WIN]
);
    win_cfg_t             cfg_d   [NUM_WIN];
    win_cfg_t             cfg_q   [NUM_WIN];
    logic [FRAME_W-1:0]   frame_d [NUM_WIN];
    logic [FRAME_W-1:0]   frame_q [NUM_WIN];

    function automatic win_cfg_t rst_cfg(int idx);
        win_cfg_t c;
        c = '0;
        if (idx == 0) begin
            c.ctrl.sg = 1'b1;
            c.mask    = 32'h007F_FFFF;
        end else if (idx == 1) begin
            c.ctrl.en = 1'b1;
            c.base    = 32'h4000_0000;
            c.mask    = 32'h3FFF_FFFF;
        end
        return c;
    endfunction

    always_comb begin
        cfg_d   = cfg_q;
        frame_d = frame_q;
        if (cfg_we && (int'(cfg_win) < NUM_WIN)) begin
            case (cfg_fld_e'(cfg_fld))
                FLD_BASE: cfg_d[cfg_win].base = cfg_wdata;
                FLD_MASK: cfg_d[cfg_win].mask = cfg_wdata;
                FLD_CTRL: cfg_d[cfg_win].ctrl = win_ctrl_t'(cfg_wdata[2:0]);
                FLD_XLAT: frame_d[cfg_win]    = cfg_wdata[FRAME_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                cfg_q[i]   <= rst_cfg(i);
                frame_q[i] <= '0;
            end
        end else begin
            cfg_q   <= cfg_d;
            frame_q <= frame_d;
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
        assign win_cfg[g]   = cfg_q[g];
        assign win_frame[g] = frame_q[g];
    end
endmodule

// File: rtl/dwx_pte_array.sv
module dwx_pte_array #(
    parameter int  SG_DEPTH = 64,
    parameter int  FRAME_W  = 21,
    localparam int IDX_W    = (SG_DEPTH > 1) ? $clog2(SG_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [FRAME_W:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [FRAME_W:0] rdata
);
    logic [FRAME_W:0] mem_d [SG_DEPTH];
    logic [FRAME_W:0] mem_q [SG_DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(widx) < SG_DEPTH)) begin
            mem_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SG_DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/dwx_match.sv
module dwx_match
    import dwx_pkg::*;
#(
    parameter int  NUM_WIN   = 5,
    parameter int  FRAME_W   = 21,
    parameter int  SYS_AW    = 34,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int PAGE_W    = PCI_LO_W - PAGE_SH
) (
    input  win_cfg_t               win_cfg   [NUM_WIN],
    input  logic [FRAME_W-1:0]     win_frame [NUM_WIN],
    input  logic [63:0]            addr,
    input  logic                   dac,
    input  logic                   cfg_acc,
    output logic                   found,
    output logic [WIN_IDX_W-1:0]   sel,
    output logic                   sel_sg,
    output logic [PAGE_W-1:0]      page,
    output logic [SYS_AW-1:0]      direct_addr
);
    logic                  hi_set;
    logic [NUM_WIN-1:0]    match;
    logic [PCI_LO_W-1:0]   offset;

    assign hi_set = dac && (addr[63:32] != '0);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign match[g] = win_cfg[g].ctrl.en && !cfg_acc &&
                          (!hi_set || win_cfg[g].ctrl.dac_ok) &&
                          ((addr[31:0] & ~win_cfg[g].mask) ==
                           (win_cfg[g].base & ~win_cfg[g].mask));
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                sel   = WIN_IDX_W'(i);
            end
        end
    end

    assign offset      = addr[31:0] & win_cfg[sel].mask;
    assign sel_sg      = win_cfg[sel].ctrl.sg;
    assign page        = offset[PCI_LO_W-1:PAGE_SH];
    assign direct_addr = {win_frame[sel], {PAGE_SH{1'b0}}} + SYS_AW'(offset);
endmodule

// File: rtl/dwx_window_xlate.sv
module dwx_window_xlate
    import dwx_pkg::*;
#(
    parameter int  NUM_WIN   = 5,
    parameter int  SYS_AW    = 34,
    parameter int  SG_DEPTH  = 64,
    localparam int FRAME_W   = SYS_AW - PAGE_SH,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int PTE_IDX_W = (SG_DEPTH > 1) ? $clog2(SG_DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [WIN_IDX_W-1:0]  cfg_win,
    input  logic [1:0]            cfg_fld,
    input  logic [31:0]           cfg_wdata,
    input  logic                  pte_we,
    input  logic [PTE_IDX_W-1:0]  pte_idx,
    input  logic [FRAME_W:0]      pte_wdata,
    input  logic                  in_valid,
    input  logic                  in_dac,
    input  logic                  in_cfg,
    input  logic [63:0]           in_addr,
    output logic                  out_valid,
    output logic                  out_hit,
    output logic                  out_err,
    output logic [WIN_IDX_W-1:0]  out_win,
    output logic [SYS_AW-1:0]     out_addr
);
    localparam int PAGE_W = PCI_LO_W - PAGE_SH;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic                 err;
        logic [WIN_IDX_W-1:0] win;
        logic [SYS_AW-1:0]    addr;
    } res_t;

    win_cfg_t              win_cfg   [NUM_WIN];
    logic [FRAME_W-1:0]    win_frame [NUM_WIN];
    logic                  found;
    logic [WIN_IDX_W-1:0]  sel;
    logic                  sel_sg;
    logic [PAGE_W-1:0]     page;
    logic [SYS_AW-1:0]     direct_addr;
    logic [FRAME_W:0]      pte_rdata;
    logic                  page_in_range;
    res_t                  res_d, res_q;

    dwx_win_regs #(.NUM_WIN(NUM_WIN), .FRAME_W(FRAME_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_fld   (cfg_fld),
        .cfg_wdata (cfg_wdata),
        .win_cfg   (win_cfg),
        .win_frame (win_frame)
    );

    dwx_match #(.NUM_WIN(NUM_WIN), .FRAME_W(FRAME_W), .SYS_AW(SYS_AW)) u_match (
        .win_cfg     (win_cfg),
        .win_frame   (win_frame),
        .addr        (in_addr),
        .dac         (in_dac),
        .cfg_acc     (in_cfg),
        .found       (found),
        .sel         (sel),
        .sel_sg      (sel_sg),
        .page        (page),
        .direct_addr (direct_addr)
    );

    dwx_pte_array #(.SG_DEPTH(SG_DEPTH), .FRAME_W(FRAME_W)) u_pte (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pte_we),
        .widx  (pte_idx),
        .wdata (pte_wdata),
        .ridx  (page[PTE_IDX_W-1:0]),
        .rdata (pte_rdata)
    );

    assign page_in_range = (int'(page) < SG_DEPTH);

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            if (found) begin
                res_d.win = sel;
                if (sel_sg) begin
                    if (page_in_range && pte_rdata[FRAME_W]) begin
                        res_d.hit  = 1'b1;
                        res_d.addr = {pte_rdata[FRAME_W-1:0], in_addr[PAGE_SH-1:0]};
                    end else begin
                        res_d.err  = 1'b1;
                    end
                end else begin
                    res_d.hit  = 1'b1;
                    res_d.addr = direct_addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_hit   = res_q.hit;
    assign out_err   = res_q.err;
    assign out_win   = res_q.win;
    assign out_addr  = res_q.addr;
endmodule

// File: rtl/dwx_xlate_chk.sv
module dwx_xlate_chk #(
    parameter int  NUM_WIN   = 5,
    parameter int  SYS_AW    = 34,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_cfg,
    input logic                 out_valid,
    input logic                 out_hit,
    input logic                 out_err,
    input logic [WIN_IDX_W-1:0] out_win,
    input logic [SYS_AW-1:0]    out_addr
);
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && !out_err && out_addr == '0));

    p_cfg_untranslated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cfg) |=> (!out_hit && !out_err));

    p_hit_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> !out_err);

    p_win_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_win) < NUM_WIN));

    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_addr == '0));
endmodule

bind dwx_window_xlate dwx_xlate_chk #(.NUM_WIN(NUM_WIN), .SYS_AW(SYS_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_cfg    (in_cfg),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_err   (out_err),
    .out_win   (out_win),
    .out_addr  (out_addr)
);

// File: tb/sim_dwx_window_xlate.sv
module sim_dwx_window_xlate;
    localparam int CLK_P = 10;

    typedef struct {
        logic        hit;
        logic        err;
        logic [2:0]  win;
        logic [33:0] addr;
        string       req;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_fld = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pte_we = 1'b0;
    logic [5:0]  pte_idx = '0;
    logic [21:0] pte_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_dac = 1'b0;
    logic        in_cfg = 1'b0;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic        out_err;
    logic [2:0]  out_win;
    logic [33:0] out_addr;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    dwx_window_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
        .pte_we(pte_we), .pte_idx(pte_idx), .pte_wdata(pte_wdata),
        .in_valid(in_valid), .in_dac(in_dac), .in_cfg(in_cfg), .in_addr(in_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_err(out_err),
        .out_win(out_win), .out_addr(out_addr)
    );

    // monitor: compares each result against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected result: actual out_valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (out_hit !== e.hit || out_err !== e.err ||
                    out_win !== e.win || out_addr !== e.addr) begin
                    fails++;
                    $display("FAIL %s %s: actual hit=%0b err=%0b win=%0d addr=%h expected hit=%0b err=%0b win=%0d addr=%h",
                             e.req, e.tag, out_hit, out_err, out_win, out_addr,
                             e.hit, e.err, e.win, e.addr);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    task automatic lookup(input logic [63:0] a, input logic dac, input logic cfgsp,
                          input logic eh, input logic ee, input logic [2:0] ew,
                          input logic [33:0] ea, input string req, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0; pte_we = 1'b0;
        in_valid = 1'b1; in_addr = a; in_dac = dac; in_cfg = cfgsp;
        e.hit = eh; e.err = ee; e.win = ew; e.addr = ea; e.req = req; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr_win(input logic [2:0] w, input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b0; pte_we = 1'b0;
        cfg_we = 1'b1; cfg_win = w; cfg_fld = f; cfg_wdata = d;
    endtask

    task automatic wr_pte(input logic [5:0] idx, input logic v, input logic [20:0] fr);
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        pte_we = 1'b1; pte_idx = idx; pte_wdata = {v, fr};
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0; pte_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R10)
        checks++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0 || out_err !== 1'b0 || out_addr !== '0) begin
            fails++;
            $display("FAIL R10 reset outputs: actual v=%0b h=%0b e=%0b a=%h expected all zero",
                     out_valid, out_hit, out_err, out_addr);
        end
        rst_n = 1'b1;

        // R1 reset windows, R4 direct offset
        lookup(64'h0000_0000_4000_1234, 0, 0, 1, 0, 1, 34'h0_0000_1234, "R1", "win1 low");
        lookup(64'h0000_0000_4ABC_DEF0, 0, 0, 1, 0, 1, 34'h0_0ABC_DEF0, "R4", "win1 mid");
        lookup(64'h0000_0000_0000_2000, 0, 0, 0, 0, 0, 34'h0, "R1", "win0 disabled");
        lookup(64'h0000_0000_7FFF_FFFF, 0, 0, 1, 0, 1, 34'h0_3FFF_FFFF, "R2", "win1 last byte");
        // R7 single cycle ignores high bits, R8 dual cycle refused
        lookup(64'hFFFF_FFFF_4000_0010, 0, 0, 1, 0, 1, 34'h0_0000_0010, "R7", "sac high ignored");
        lookup(64'hFFFF_FFFF_4000_0010, 1, 0, 0, 0, 0, 34'h0, "R8", "dac refused");
        lookup(64'h0000_0000_4000_0010, 0, 1, 0, 0, 0, 34'h0, "R9", "config space");
        idle();
        @(negedge clk);
        // R10 idle cycle quiet
        checks++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0 || out_addr !== '0) begin
            fails++;
            $display("FAIL R10 idle: actual v=%0b h=%0b a=%h expected zero", out_valid, out_hit, out_addr);
        end

        // R11 program window 2: 16 MB direct at 0x8000_0000, dual accept, to 0x3000_0000
        wr_win(3'd2, 2'd0, 32'h8000_0000);
        wr_win(3'd2, 2'd1, 32'h00FF_FFFF);
        wr_win(3'd2, 2'd3, 32'h0001_8000);
        wr_win(3'd2, 2'd2, 32'h0000_0005);
        lookup(64'h0000_0000_8012_3456, 0, 0, 1, 0, 2, 34'h0_3012_3456, "R11", "win2 direct");
        lookup(64'h0000_0001_8000_0040, 1, 0, 1, 0, 2, 34'h0_3000_0040, "R8", "dac accepted");
        lookup(64'h0000_0000_80FF_FFFF, 0, 0, 1, 0, 2, 34'h0_30FF_FFFF, "R2", "win2 last byte");
        lookup(64'h0000_0000_8100_0000, 0, 0, 0, 0, 0, 34'h0, "R2", "past win2");

        // R5/R6 scatter/gather window 0 over the bottom of window 2
        wr_pte(6'd2, 1'b1, 21'h1_2345);
        wr_pte(6'd63, 1'b1, 21'h0_0ABC);
        wr_win(3'd0, 2'd0, 32'h8000_0000);
        wr_win(3'd0, 2'd2, 32'h0000_0003);
        lookup(64'h0000_0000_8000_4ABC, 0, 0, 1, 0, 0, 34'h0_2468_AABC, "R5", "sg page 2");
        lookup(64'h0000_0000_8000_2010, 0, 0, 0, 1, 0, 34'h0, "R6", "sg invalid entry");
        lookup(64'h0000_0000_8007_E008, 0, 0, 1, 0, 0, 34'h0_0157_8008, "R5", "sg page 63");
        lookup(64'h0000_0000_8008_0000, 0, 0, 0, 1, 0, 34'h0, "R6", "sg page out of range");
        lookup(64'h0000_0000_8080_0000, 0, 0, 1, 0, 2, 34'h0_3080_0000, "R3", "past win0 to win2");
        lookup(64'h0000_0001_8000_4ABC, 1, 0, 1, 0, 2, 34'h0_3000_4ABC, "R8", "dac skips win0");

        // R11 disable window 2
        wr_win(3'd2, 2'd2, 32'h0000_0000);
        lookup(64'h0000_0000_8080_0000, 0, 0, 0, 0, 0, 34'h0, "R11", "win2 disabled");
        idle();
        repeat (3) @(negedge clk);

        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing results: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule